// File: doc/BRIEF.md
# Floppy Drive Control and Status Port

This block is the register front end placed between a host byte bus and two floppy disk controllers, one for a high-density interface and one for a double-density interface. For each interface it keeps a side-select register and a drive/motor register, and it drives the side, drive-select and motor lines of that controller from registered flops. The two interfaces differ in motor polarity: the double-density motor runs while bit 7 of its drive register is set, and the high-density motor runs while that bit is clear.

The host also reads composed bytes. The drive-sense byte reports media presence for up to four high-density drives, but only while the high-density motor is running. It also reports the rotation speed and the side count of the drive currently selected. Each interface has a status byte that carries the controller's interrupt and data-request levels. Reads are registered, so the data for an address presented in one cycle is on `bus_rdata` after the next rising edge.

Top module: `fdc_port_regs`

## Requirements
- R1: A write to a side register (address 0 for high-density, address 4 for double-density) stores the whole byte. Reads of that address return the whole byte, and the side output of that interface follows bit 0.
- R2: A write to the double-density drive register (address 5) sets `dd_motor_on` to bit 7 and `dd_drive_sel` to bits 1:0. Reads of address 5 return the written byte unchanged.
- R3: A write to the high-density drive register (address 1) sets `hd_motor_on` to the inverse of bit 7 and `hd_drive_sel` to bits 1:0. Reads of address 1 return the written byte unchanged.
- R4: Synchronous reset sets the high-density drive register to 0x00 and the double-density drive register to 0x80. It clears both side registers and `bus_rdata`. Both interfaces then select drive 0 with the motor running and side 0.
- R5: The drive-sense byte (address 2) always has bit 6 set and bit 4 clear. Bits 3:0 equal `hd_present` while `hd_motor_on` is high and read 0 while it is low.
- R6: Drive-sense bit 5 equals `hd_rpm300` of the drive selected by `hd_drive_sel`. Bit 7 is set when that drive has media present and `hd_two_side` set for it. Neither bit depends on the motor.
- R7: Status reads return {drq, irq, 6'b0}, that is data request in bit 7 and interrupt in bit 6, with all other bits zero. Address 3 reads the high-density levels and address 6 reads the double-density levels.
- R8: A write sampled at a rising edge changes the register and its output lines at that edge. `bus_rdata` after an edge reflects the address, the inputs and the register contents as they were just before that edge, so a read in the cycle after a write returns the new value.
- R9: Address 7 reads 0xFF. Writes to addresses 2, 3, 6 and 7 change no register and no output line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| hd_present | input | NUM_DRIVES | Media present, per high-density drive |
| hd_rpm300 | input | NUM_DRIVES | Media spins at 300 rpm, per high-density drive |
| hd_two_side | input | NUM_DRIVES | Media is double-sided, per high-density drive |
| hd_irq | input | 1 | High-density controller interrupt level |
| hd_drq | input | 1 | High-density controller data request level |
| dd_irq | input | 1 | Double-density controller interrupt level |
| dd_drq | input | 1 | Double-density controller data request level |
| hd_side | output | 1 | High-density side select |
| hd_drive_sel | output | 2 | High-density drive select |
| hd_motor_on | output | 1 | High-density motor on |
| dd_side | output | 1 | Double-density side select |
| dd_drive_sel | output | 2 | Double-density drive select |
| dd_motor_on | output | 1 | Double-density motor on |

## Verification
The hardest case to reach is a drive-sense read taken while the high-density motor is stopped and the selected drive holds double-sided 300 rpm media. In that state the presence bits must read zero while bits 5 and 7 still report the media. The bus cannot reach this state directly: the bench must first write a drive register value with bit 7 set, which stops the motor, select a drive whose presence, speed and side inputs are all high, and then read the sense byte. After the directed sequence, a long deterministic pseudo-random run mixes writes, reads of every address and changing drive inputs. This covers the ordering of back-to-back write then read, and a reference model compares every output on every cycle.

// File: rtl/fdc_port_pkg.sv
package fdc_port_pkg;

  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int SENSE_SLOTS = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_HD_SIDE   = 3'd0,
    A_HD_DRIVE  = 3'd1,
    A_HD_SENSE  = 3'd2,
    A_HD_STATUS = 3'd3,
    A_DD_SIDE   = 3'd4,
    A_DD_DRIVE  = 3'd5,
    A_DD_STATUS = 3'd6,
    A_UNMAPPED  = 3'd7
  } fdc_addr_e;

  localparam logic [BYTE_W-1:0] HD_DRIVE_RST = 8'h00;
  localparam logic [BYTE_W-1:0] DD_DRIVE_RST = 8'h80;
  localparam logic [BYTE_W-1:0] IDLE_READ    = 8'hFF;

  // Controller status byte: request on top, interrupt just below.
  function automatic logic [BYTE_W-1:0] status_byte(input logic irq, input logic drq);
    status_byte = {drq, irq, {(BYTE_W-2){1'b0}}};
  endfunction

endpackage

// File: rtl/fdc_drive_regs.sv
module fdc_drive_regs
  import fdc_port_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DRIVE_RESET = 8'h00,
  parameter bit                MOTOR_INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              side_we,
  input  logic              drive_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] side_q,
  output logic [BYTE_W-1:0] drive_q,
  output logic              side_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              motor_o
);

  localparam int MOTOR_BIT = BYTE_W - 1;
  localparam logic MOTOR_RST = DRIVE_RESET[MOTOR_BIT] ^ MOTOR_INVERT;

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q <= '0;
      side_o <= 1'b0;
    end else if (side_we) begin
      side_q <= wdata;
      side_o <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= DRIVE_RESET;
      sel_o   <= DRIVE_RESET[SEL_W-1:0];
      motor_o <= MOTOR_RST;
    end else if (drive_we) begin
      drive_q <= wdata;
      sel_o   <= wdata[SEL_W-1:0];
      motor_o <= wdata[MOTOR_BIT] ^ MOTOR_INVERT;
    end
  end

endmodule

// File: rtl/fdc_sense_build.sv
module fdc_sense_build
  import fdc_port_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic [NUM_DRIVES-1:0] present,
  input  logic [NUM_DRIVES-1:0] rpm300,
  input  logic [NUM_DRIVES-1:0] two_side,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  motor_on,
  output logic [BYTE_W-1:0]     sense
);

  logic [SENSE_SLOTS-1:0] pres_w;
  logic [SENSE_SLOTS-1:0] rpm_w;
  logic [SENSE_SLOTS-1:0] dbl_w;

  for (genvar i = 0; i < SENSE_SLOTS; i++) begin : g_slot
    if (i < NUM_DRIVES) begin : g_live
      assign pres_w[i] = present[i];
      assign rpm_w[i]  = rpm300[i];
      assign dbl_w[i]  = present[i] & two_side[i];
    end else begin : g_pad
      assign pres_w[i] = 1'b0;
      assign rpm_w[i]  = 1'b0;
      assign dbl_w[i]  = 1'b0;
    end
  end

  always_comb begin
    sense      = '0;
    sense[3:0] = motor_on ? pres_w : '0;
    sense[5]   = rpm_w[sel];
    sense[6]   = 1'b1;
    sense[7]   = dbl_w[sel];
  end

endmodule

// File: rtl/fdc_port_regs.sv
module fdc_port_regs
  import fdc_port_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [NUM_DRIVES-1:0] hd_present,
  input  logic [NUM_DRIVES-1:0] hd_rpm300,
  input  logic [NUM_DRIVES-1:0] hd_two_side,
  input  logic                  hd_irq,
  input  logic                  hd_drq,
  input  logic                  dd_irq,
  input  logic                  dd_drq,
  output logic                  hd_side,
  output logic [1:0]            hd_drive_sel,
  output logic                  hd_motor_on,
  output logic                  dd_side,
  output logic [1:0]            dd_drive_sel,
  output logic                  dd_motor_on
);

  fdc_addr_e addr_e;
  assign addr_e = fdc_addr_e'(bus_addr);

  logic hd_side_we, hd_drive_we, dd_side_we, dd_drive_we;
  assign hd_side_we  = bus_wr && (addr_e == A_HD_SIDE);
  assign hd_drive_we = bus_wr && (addr_e == A_HD_DRIVE);
  assign dd_side_we  = bus_wr && (addr_e == A_DD_SIDE);
  assign dd_drive_we = bus_wr && (addr_e == A_DD_DRIVE);

  logic [BYTE_W-1:0] hd_side_q, hd_drive_q, dd_side_q, dd_drive_q;
  logic [BYTE_W-1:0] hd_sense;

  fdc_drive_regs #(
    .DRIVE_RESET (HD_DRIVE_RST),
    .MOTOR_INVERT(1'b1)
  ) u_hd_regs (
    .clk     (clk),
    .rst     (rst),
    .side_we (hd_side_we),
    .drive_we(hd_drive_we),
    .wdata   (bus_wdata),
    .side_q  (hd_side_q),
    .drive_q (hd_drive_q),
    .side_o  (hd_side),
    .sel_o   (hd_drive_sel),
    .motor_o (hd_motor_on)
  );

  fdc_drive_regs #(
    .DRIVE_RESET (DD_DRIVE_RST),
    .MOTOR_INVERT(1'b0)
  ) u_dd_regs (
    .clk     (clk),
    .rst     (rst),
    .side_we (dd_side_we),
    .drive_we(dd_drive_we),
    .wdata   (bus_wdata),
    .side_q  (dd_side_q),
    .drive_q (dd_drive_q),
    .side_o  (dd_side),
    .sel_o   (dd_drive_sel),
    .motor_o (dd_motor_on)
  );

  fdc_sense_build #(
    .NUM_DRIVES(NUM_DRIVES)
  ) u_sense (
    .present (hd_present),
    .rpm300  (hd_rpm300),
    .two_side(hd_two_side),
    .sel     (hd_drive_sel),
    .motor_on(hd_motor_on),
    .sense   (hd_sense)
  );

  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    unique case (addr_e)
      A_HD_SIDE:   rd_mux = hd_side_q;
      A_HD_DRIVE:  rd_mux = hd_drive_q;
      A_HD_SENSE:  rd_mux = hd_sense;
      A_HD_STATUS: rd_mux = status_byte(hd_irq, hd_drq);
      A_DD_SIDE:   rd_mux = dd_side_q;
      A_DD_DRIVE:  rd_mux = dd_drive_q;
      A_DD_STATUS: rd_mux = status_byte(dd_irq, dd_drq);
      default:     rd_mux = IDLE_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/fdc_port_regs_chk.sv
module fdc_port_regs_chk #(
  parameter int NUM_DRIVES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2:0]            bus_addr,
  input logic                  bus_wr,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic [NUM_DRIVES-1:0] hd_present,
  input logic                  hd_irq,
  input logic                  hd_drq,
  input logic                  dd_irq,
  input logic                  dd_drq,
  input logic                  hd_side,
  input logic [1:0]            hd_drive_sel,
  input logic                  hd_motor_on,
  input logic                  dd_side,
  input logic [1:0]            dd_drive_sel,
  input logic                  dd_motor_on
);

  assert_hd_side_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0) |=> (hd_side == $past(bus_wdata[0])));

  assert_dd_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd5) |=>
      (dd_motor_on == $past(bus_wdata[7]) && dd_drive_sel == $past(bus_wdata[1:0])));

  assert_hd_motor_inv_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd1) |=>
      (hd_motor_on == !$past(bus_wdata[7]) && hd_drive_sel == $past(bus_wdata[1:0])));

  assert_sense_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd2) |=> (bus_rdata[6] && !bus_rdata[4]));

  assert_sense_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd2 && !hd_motor_on) |=> (bus_rdata[3:0] == 4'h0));

  assert_hd_status_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd3) |=> (bus_rdata == {$past(hd_drq), $past(hd_irq), 6'b0}));

  assert_dd_status_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd6) |=> (bus_rdata == {$past(dd_drq), $past(dd_irq), 6'b0}));

  assert_hold_hd_R8: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 3'd1) |=> ($stable(hd_motor_on) && $stable(hd_drive_sel)));

  assert_hold_dd_R8: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5)) |=>
      ($stable(dd_side) && $stable(dd_motor_on) && $stable(dd_drive_sel)));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 3'd7) |=> (bus_rdata == 8'hFF));

  assert_hd_side_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 3'd0) |=> $stable(hd_side));

endmodule

bind fdc_port_regs fdc_port_regs_chk #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .hd_present  (hd_present),
  .hd_irq      (hd_irq),
  .hd_drq      (hd_drq),
  .dd_irq      (dd_irq),
  .dd_drq      (dd_drq),
  .hd_side     (hd_side),
  .hd_drive_sel(hd_drive_sel),
  .hd_motor_on (hd_motor_on),
  .dd_side     (dd_side),
  .dd_drive_sel(dd_drive_sel),
  .dd_motor_on (dd_motor_on)
);

// File: tb/fdc_port_regs_tb.sv
module fdc_port_regs_tb;

  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [ND-1:0] hd_present = '0, hd_rpm300 = '0, hd_two_side = '0;
  logic          hd_irq = 0, hd_drq = 0, dd_irq = 0, dd_drq = 0;
  logic          hd_side, hd_motor_on, dd_side, dd_motor_on;
  logic [1:0]    hd_drive_sel, dd_drive_sel;

  always #10 clk = ~clk;

  fdc_port_regs #(.NUM_DRIVES(ND)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hd_present(hd_present), .hd_rpm300(hd_rpm300), .hd_two_side(hd_two_side),
    .hd_irq(hd_irq), .hd_drq(hd_drq), .dd_irq(dd_irq), .dd_drq(dd_drq),
    .hd_side(hd_side), .hd_drive_sel(hd_drive_sel), .hd_motor_on(hd_motor_on),
    .dd_side(dd_side), .dd_drive_sel(dd_drive_sel), .dd_motor_on(dd_motor_on)
  );

  // Behavioural reference model
  logic [7:0] m_hd_side, m_hd_drv, m_dd_side, m_dd_drv, m_rdata;
  string      m_tag;
  bit         started = 0;
  int         checks = 0, fails = 0, cycles = 0;
  bit         done = 0;

  function automatic logic [7:0] model_read(input logic [2:0] a);
    logic [7:0] v;
    logic       mot;
    mot = ~m_hd_drv[7];
    case (a)
      3'd0: v = m_hd_side;
      3'd1: v = m_hd_drv;
      3'd2: begin
        v = 8'h40;
        if (mot) v[3:0] = hd_present;
        v[5] = hd_rpm300[m_hd_drv[1:0]];
        v[7] = hd_present[m_hd_drv[1:0]] & hd_two_side[m_hd_drv[1:0]];
      end
      3'd3: v = {hd_drq, hd_irq, 6'b0};
      3'd4: v = m_dd_side;
      3'd5: v = m_dd_drv;
      3'd6: v = {dd_drq, dd_irq, 6'b0};
      default: v = 8'hFF;
    endcase
    return v;
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd4: return "R1 R8";
      3'd1: return "R3 R8";
      3'd2: return "R5/R6";
      3'd3, 3'd6: return "R7";
      3'd5: return "R2 R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_hd_side = 8'h00; m_dd_side = 8'h00;
      m_hd_drv  = 8'h00; m_dd_drv  = 8'h80;
      m_rdata   = 8'h00; m_tag = "R4";
    end else begin
      m_rdata = model_read(bus_addr);
      m_tag   = read_tag(bus_addr);
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_hd_side = bus_wdata;
          3'd1: m_hd_drv  = bus_wdata;
          3'd4: m_dd_side = bus_wdata;
          3'd5: m_dd_drv  = bus_wdata;
          default: ;  // R9: read-only and unmapped addresses ignore writes
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(m_tag, "bus_rdata", bus_rdata, m_rdata);
      chk("R1", "hd_side", {7'b0, hd_side}, {7'b0, m_hd_side[0]});
      chk("R1", "dd_side", {7'b0, dd_side}, {7'b0, m_dd_side[0]});
      chk("R3", "hd_motor_on", {7'b0, hd_motor_on}, {7'b0, ~m_hd_drv[7]});
      chk("R3", "hd_drive_sel", {6'b0, hd_drive_sel}, {6'b0, m_hd_drv[1:0]});
      chk("R2", "dd_motor_on", {7'b0, dd_motor_on}, {7'b0, m_dd_drv[7]});
      chk("R2", "dd_drive_sel", {6'b0, dd_drive_sel}, {6'b0, m_dd_drv[1:0]});
    end
  end

  task automatic cyc(input logic [2:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cycles);
        finish_run();
      end
    end
  end

  int unsigned lcg = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R4: reset contents read back
    for (int a = 0; a < 8; a++) cyc(a[2:0], 0, 0);
    // R1: side register full byte
    cyc(3'd0, 1, 8'hA5); cyc(3'd0, 0, 0); cyc(3'd4, 1, 8'h3C); cyc(3'd4, 0, 0);
    // R3: high-density motor off, drive 3
    hd_present = 4'b1011; hd_rpm300 = 4'b0010; hd_two_side = 4'b1010;
    cyc(3'd1, 1, 8'h83); cyc(3'd1, 0, 0);
    // R5/R6: motor stopped, selected drive 3 double-sided
    cyc(3'd2, 0, 0);
    cyc(3'd1, 1, 8'h81); cyc(3'd2, 0, 0);
    cyc(3'd1, 1, 8'h01); cyc(3'd2, 0, 0);
    cyc(3'd1, 1, 8'h72); cyc(3'd2, 0, 0); cyc(3'd1, 0, 0);
    // R2: double-density motor polarity
    cyc(3'd5, 1, 8'h03); cyc(3'd5, 0, 0); cyc(3'd5, 1, 8'hFE); cyc(3'd5, 0, 0);
    // R7: status bytes
    hd_irq = 1; cyc(3'd3, 0, 0); hd_drq = 1; hd_irq = 0; cyc(3'd3, 0, 0);
    dd_irq = 1; dd_drq = 1; cyc(3'd6, 0, 0); dd_irq = 0; cyc(3'd6, 0, 0);
    // R9: ignored writes, unmapped read
    cyc(3'd2, 1, 8'h00); cyc(3'd3, 1, 8'hFF); cyc(3'd6, 1, 8'h55); cyc(3'd7, 1, 8'h81);
    for (int a = 0; a < 8; a++) cyc(a[2:0], 0, 0);
    // Mixed deterministic traffic
    for (int i = 0; i < 600; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      hd_present = lcg[11:8]; hd_rpm300 = lcg[15:12]; hd_two_side = lcg[19:16];
      hd_irq = lcg[20]; hd_drq = lcg[21]; dd_irq = lcg[22]; dd_drq = lcg[23];
      cyc(lcg[26:24], lcg[27], lcg[31:24] ^ lcg[7:0]);
    end
    // R4: reset in mid-run
    @(negedge clk); rst = 1; bus_wr = 0;
    @(negedge clk); rst = 0;
    for (int a = 0; a < 8; a++) cyc(a[2:0], 0, 0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule